// File: doc/BRIEF.md
# Fast A20 and CPU Reset Port

This block is a one-byte host I/O register that gives system firmware a quick route to two controls. The first is the A20 address gate: the gate output is the OR of a register bit and the A20 request coming from the keyboard controller. The second is a CPU reset pulse that software can trigger. Setting the reset bit starts a fixed delay. After the delay, an active-low reset output is held low for a fixed number of clock cycles.

Software reaches the register with ordinary reads and writes on a simple synchronous I/O bus. The register answers at address 0x0092 only, and only while the enable input from the configuration logic is high. The delay and the pulse width are specified in microseconds. At elaboration they are converted to clock cycles from the clock frequency parameter, rounding up. The reset pulse is one-shot. To fire it again, software must first write the reset bit back to 0, then set it once more.

Top module: `fast_gate_port`

## Requirements
- R1: The register responds only when the full 16-bit address equals 0x0092. Writes to any other address leave it unchanged, and reads of any other address do not assert the read enable.
- R2: While `rst_n` is low at a clock edge, both stored bits clear to 0. After reset, a read returns 0x00 and `gate_a20` follows `kbc_a20`.
- R3: While `port_en` is low, writes have no effect, `io_rdata_oe` stays low and `io_rdata` is 0x00.
- R4: Written data bits 7 to 2 are discarded. Bits 7 to 2 always read back as 0.
- R5: Bit 1 is the A20 control. `gate_a20` equals bit 1 OR `kbc_a20`, and it reflects a write from the cycle after the write edge.
- R6: An enabled read at 0x0092 asserts `io_rdata_oe` combinationally for as long as `io_rd` is high. During that read, `io_rdata` = {6'b0, bit 1, bit 0}.
- R7: Bit 0 is the reset control. A write that takes bit 0 from 0 to 1 drives `alt_rst_n` low exactly DELAY_CYC cycles after the write edge. DELAY_CYC = ceil(14 µs × clock), which is 1750 at the 125 MHz default.
- R8: The low pulse on `alt_rst_n` lasts exactly PULSE_CYC cycles. PULSE_CYC = ceil(6 µs × clock), which is 750 at the default.
- R9: Writing 1 to bit 0 while it already holds 1 starts no sequence. After bit 0 has been written to 0, a new write of 1 starts one.
- R10: While `rst_n` is low, `alt_rst_n` is high at once, without waiting for a clock edge, and any delay or pulse in progress is abandoned.
- R11: Writing bit 0 to 0 during the delay or the pulse does not shorten or cancel the sequence.
- R12: A 0-to-1 transition of bit 0 made while a sequence is running does not start a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, sampled at the clock edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 when not selected |
| io_rdata_oe | output | 1 | Read data drive enable |
| port_en | input | 1 | Register enable from configuration logic |
| kbc_a20 | input | 1 | A20 request from the keyboard controller |
| gate_a20 | output | 1 | Combined A20 gate |
| alt_rst_n | output | 1 | Active-low alternate CPU reset pulse |

## Verification
The checker assumes that the bus strobes and `port_en` are driven synchronously and held steady across each clock edge. It also assumes that `rst_n` is the only thing that can clear the stored bits, so whenever `port_en` is low, any change in those bits means a write got through. The stimulus changes every input at the falling edge, leaves at least one full cycle between bus operations, and toggles `port_en` and `kbc_a20` only between operations. The measured delay and pulse width therefore depend only on the write edge.

// File: rtl/fgp_pkg.sv
// Package: shared types and cycle arithmetic for the fast A20 / reset port.
// Assumes the clock frequency is given in kHz so that cycle counts round up.
package fgp_pkg;

    // Timer sequence states
    typedef enum logic [1:0] {
        TMR_IDLE  = 2'd0,
        TMR_DELAY = 2'd1,
        TMR_PULSE = 2'd2
    } tmr_state_e;

    // The two live control bits of the register
    typedef struct packed {
        logic a20;
        logic rst;
    } ctl_bits_t;

    // Convert microseconds to clock cycles, rounding up; never below one
    function automatic int us_to_cycles(input int us, input int clk_khz);
        int c;
        c = (us * clk_khz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/fgp_bus_decode.sv
// Module: bus decode and read-data path of the port register.
// Qualifies write and read strobes with the address match and the enable,
// and presents the two stored bits with zeros above them while read.
// Assumes strobes are synchronous to the clock of the register behind it.
module fgp_bus_decode
    import fgp_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic              port_en,
    input  ctl_bits_t         ctl_q,
    output logic              wr_hit,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rdata_oe
);

    localparam int CTL_W = $bits(ctl_bits_t);

    logic addr_hit;
    logic rd_hit;

    // Full address compare, gated by the configuration enable
    always_comb begin
        addr_hit = port_en && (io_addr == PORT_ADDR);
        wr_hit   = addr_hit && io_wr;
        rd_hit   = addr_hit && io_rd;
    end

    // Read data: stored bits in the low positions, reserved bits forced to 0
    always_comb begin
        io_rdata    = '0;
        io_rdata_oe = rd_hit;
        if (rd_hit) begin
            io_rdata[CTL_W-1:0] = ctl_q;
        end
    end

endmodule

// File: rtl/fgp_ctl_reg.sv
// Module: storage for the A20 and reset control bits.
// Captures bits 1 and 0 on a qualified write and raises a one-cycle start
// request when the reset bit moves from 0 to 1 (the re-arm rule).
// Assumes wr_hit already includes address and enable qualification.
module fgp_ctl_reg
    import fgp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output ctl_bits_t         ctl_q,
    output logic              start_req
);

    localparam int A20_BIT = 1;
    localparam int RST_BIT = 0;

    logic unused_hi_bits;
    assign unused_hi_bits = ^wdata[DATA_W-1:2];

    // Register update on a qualified write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_hit) begin
            ctl_q.a20 <= wdata[A20_BIT];
            ctl_q.rst <= wdata[RST_BIT];
        end
    end

    // Trigger only on a 0-to-1 move of the reset bit
    always_comb begin
        start_req = wr_hit && wdata[RST_BIT] && !ctl_q.rst;
    end

endmodule

// File: rtl/fgp_pulse_timer.sv
// Module: delay-then-pulse sequencer for the alternate CPU reset.
// On start it waits DELAY_CYC cycles, then holds pulse_on for PULSE_CYC
// cycles and returns to idle. Starts arriving while busy are dropped.
// Assumes both counts are at least 1.
module fgp_pulse_timer
    import fgp_pkg::*;
#(
    parameter int DELAY_CYC = 1750,
    parameter int PULSE_CYC = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_on
);

    localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] DELAY_LOAD = CNT_W'(DELAY_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);

    tmr_state_e       state;
    logic [CNT_W-1:0] cnt;

    // Sequencer: idle -> delay -> pulse -> idle, reset returns to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TMR_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                TMR_IDLE: begin
                    if (start) begin
                        state <= TMR_DELAY;
                        cnt   <= DELAY_LOAD;
                    end
                end
                TMR_DELAY: begin
                    if (cnt == '0) begin
                        state <= TMR_PULSE;
                        cnt   <= PULSE_LOAD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                TMR_PULSE: begin
                    if (cnt == '0) begin
                        state <= TMR_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= TMR_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Pulse indication straight from the state register
    always_comb begin
        pulse_on = (state == TMR_PULSE);
    end

endmodule

// File: rtl/fast_gate_port.sv
// Module: fast A20 gate and alternate CPU reset register at I/O 0x0092.
// Combines the A20 register bit with the keyboard-controller request and
// drives a delayed, fixed-width, one-shot active-low reset pulse.
// Assumes a single clock; rst_n is synchronous for state and also forces
// the reset output inactive combinationally.
module fast_gate_port
    import fgp_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
    parameter int              CLK_KHZ   = 125000,
    parameter int              DELAY_US  = 14,
    parameter int              PULSE_US  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rdata_oe,
    input  logic              port_en,
    input  logic              kbc_a20,
    output logic              gate_a20,
    output logic              alt_rst_n
);

    localparam int DELAY_CYC = us_to_cycles(DELAY_US, CLK_KHZ);
    localparam int PULSE_CYC = us_to_cycles(PULSE_US, CLK_KHZ);

    ctl_bits_t ctl_q;
    logic      wr_hit;
    logic      start_req;
    logic      pulse_on;

    fgp_bus_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .io_addr     (io_addr),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .port_en     (port_en),
        .ctl_q       (ctl_q),
        .wr_hit      (wr_hit),
        .io_rdata    (io_rdata),
        .io_rdata_oe (io_rdata_oe)
    );

    fgp_ctl_reg #(
        .DATA_W (DATA_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wdata     (io_wdata),
        .ctl_q     (ctl_q),
        .start_req (start_req)
    );

    fgp_pulse_timer #(
        .DELAY_CYC (DELAY_CYC),
        .PULSE_CYC (PULSE_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_req),
        .pulse_on (pulse_on)
    );

    // Output combining: A20 OR and reset pulse forced idle during reset
    always_comb begin
        gate_a20  = ctl_q.a20 | kbc_a20;
        alt_rst_n = !(pulse_on && rst_n);
    end

endmodule

// File: rtl/fgp_checker.sv
// Module: property checker for fast_gate_port, attached by bind.
// Measures the reset pulse width with its own counter and checks the
// bus, A20 and reset behaviour at the block's ports.
module fgp_checker #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092,
    parameter int              PULSE_CYC = 750
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              io_rdata_oe,
    input logic              port_en,
    input logic              gate_a20,
    input logic              alt_rst_n,
    input logic [1:0]        ctl_bits
);

    localparam int LW = $clog2(PULSE_CYC + 2);
    localparam logic [LW-1:0] LMAX = {LW{1'b1}};

    logic [LW-1:0] low_cnt;

    // Count sampled low cycles of the reset output, saturating
    always_ff @(posedge clk) begin
        if (alt_rst_n) low_cnt <= '0;
        else if (low_cnt != LMAX) low_cnt <= low_cnt + 1'b1;
    end

    AST_RST_FORCES_IDLE: assert property (@(posedge clk) !rst_n |-> alt_rst_n); // R10
    AST_OE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) !port_en |-> !io_rdata_oe); // R3
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!port_en && rst_n) |=> $stable(ctl_bits)); // R3
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) io_rdata[DATA_W-1:2] == '0); // R4
    AST_A20_SET_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) (port_en && io_wr && io_addr == PORT_ADDR && io_wdata[1]) |=> gate_a20); // R5
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (alt_rst_n && low_cnt != '0) |-> (low_cnt == LW'(PULSE_CYC))); // R8

endmodule

bind fast_gate_port fgp_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PORT_ADDR (PORT_ADDR),
    .PULSE_CYC (PULSE_CYC)
) u_fgp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .io_rdata_oe (io_rdata_oe),
    .port_en     (port_en),
    .gate_a20    (gate_a20),
    .alt_rst_n   (alt_rst_n),
    .ctl_bits    (ctl_q)
);

// File: tb/fast_gate_port_bench.sv
// Directed bench for fast_gate_port: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are sampled
// on the falling edge or shortly after an input change.
module fast_gate_port_bench;

    localparam int DLY = 1750;
    localparam int PLS = 750;
    localparam logic [15:0] PA = 16'h0092;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic        port_en = 1'b1;
    logic        kbc_a20 = 1'b0;
    logic        gate_a20;
    logic        alt_rst_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int fall_cnt = 0;
    int fall_cyc = 0;
    int rise_cyc = 0;
    logic prev_alt = 1'b1;
    bit done = 0;

    always #4 clk = ~clk;

    fast_gate_port u_fast_gate_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_addr     (io_addr),
        .io_wr       (io_wr),
        .io_rd       (io_rd),
        .io_wdata    (io_wdata),
        .io_rdata    (io_rdata),
        .io_rdata_oe (io_rdata_oe),
        .port_en     (port_en),
        .kbc_a20     (kbc_a20),
        .gate_a20    (gate_a20),
        .alt_rst_n   (alt_rst_n)
    );

    // Edge counter
    always @(posedge clk) cyc <= cyc + 1;

    // Reset output monitor on the falling edge
    always @(negedge clk) begin
        if (prev_alt && !alt_rst_n) begin
            fall_cnt <= fall_cnt + 1;
            fall_cyc <= cyc;
        end
        if (!prev_alt && alt_rst_n) rise_cyc <= cyc;
        prev_alt <= alt_rst_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, output int c0);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        c0 = cyc;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; oe = io_rdata_oe;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] d; logic oe;
        bus_read(PA, d, oe);
        check(d == 8'h00 && oe, "R2 reset read", int'(d), 0);
        check(alt_rst_n == 1'b1, "R2 alt_rst_n idle", int'(alt_rst_n), 1);
        check(gate_a20 == kbc_a20, "R2 gate follows kbc", int'(gate_a20), int'(kbc_a20));
    endtask

    task automatic t_a20_truth();
        int c0;
        for (int r = 0; r < 2; r++) begin
            bus_write(PA, r[0] ? 8'h02 : 8'h00, c0);
            for (int k = 0; k < 2; k++) begin
                @(negedge clk); kbc_a20 = k[0]; #1;
                check(gate_a20 == (r[0] | k[0]), "R5 A20 OR", int'(gate_a20), int'(r[0] | k[0]));
            end
        end
        kbc_a20 = 1'b0;
        bus_write(PA, 8'h00, c0);
    endtask

    task automatic t_readback_reserved();
        logic [7:0] d; logic oe; int c0;
        bus_write(PA, 8'hFE, c0);
        bus_read(PA, d, oe);
        check(d == 8'h02, "R4 reserved bits read 0", int'(d), 2);
        check(oe == 1'b1, "R6 oe during read", int'(oe), 1);
        @(negedge clk); #1;
        check(io_rdata_oe == 1'b0 && io_rdata == 8'h00, "R6 oe drops without strobe", int'(io_rdata_oe), 0);
        bus_write(PA, 8'hFC, c0);
        bus_read(PA, d, oe);
        check(d == 8'h00, "R6 readback cleared", int'(d), 0);
    endtask

    task automatic t_addr_decode();
        logic [7:0] d; logic oe; int c0;
        bus_write(16'h0093, 8'h02, c0);
        bus_write(16'h1092, 8'h02, c0);
        check(gate_a20 == 1'b0, "R1 other address ignored", int'(gate_a20), 0);
        bus_read(16'h0093, d, oe);
        check(oe == 1'b0, "R1 no oe off-address", int'(oe), 0);
        bus_read(PA, d, oe);
        check(d == 8'h00, "R1 register unchanged", int'(d), 0);
    endtask

    task automatic t_disabled();
        logic [7:0] d; logic oe; int c0; int f0;
        f0 = fall_cnt;
        port_en = 1'b0;
        bus_write(PA, 8'h02, c0);
        check(gate_a20 == 1'b0, "R3 disabled write ignored", int'(gate_a20), 0);
        bus_read(PA, d, oe);
        check(oe == 1'b0 && d == 8'h00, "R3 disabled read undriven", int'(oe), 0);
        bus_write(PA, 8'h01, c0);
        wait_cyc(DLY + PLS + 20);
        check(fall_cnt == f0, "R3 disabled no pulse", fall_cnt - f0, 0);
        port_en = 1'b1;
        bus_read(PA, d, oe);
        check(d == 8'h00, "R3 register still zero", int'(d), 0);
    endtask

    task automatic t_pulse_timing();
        int c0; int f0;
        f0 = fall_cnt;
        bus_write(PA, 8'h01, c0);
        wait_cyc(DLY + PLS + 20);
        check(fall_cnt == f0 + 1, "R7 one pulse", fall_cnt - f0, 1);
        check(fall_cyc - c0 == DLY, "R7 delay cycles", fall_cyc - c0, DLY);
        check(rise_cyc - fall_cyc == PLS, "R8 pulse width", rise_cyc - fall_cyc, PLS);
    endtask

    task automatic t_no_retrigger();
        int c0; int f0;
        f0 = fall_cnt;
        bus_write(PA, 8'h01, c0);
        wait_cyc(DLY + PLS + 20);
        check(fall_cnt == f0, "R9 rewrite of 1 ignored", fall_cnt - f0, 0);
        bus_write(PA, 8'h00, c0);
        bus_write(PA, 8'h01, c0);
        wait_cyc(DLY + PLS + 20);
        check(fall_cnt == f0 + 1, "R9 re-armed pulse", fall_cnt - f0, 1);
        check(fall_cyc - c0 == DLY, "R9 re-armed delay", fall_cyc - c0, DLY);
        bus_write(PA, 8'h00, c0);
    endtask

    task automatic t_clear_midway();
        int c0; int cx; int f0;
        f0 = fall_cnt;
        bus_write(PA, 8'h01, c0);
        wait_cyc(10);
        bus_write(PA, 8'h00, cx);
        wait_cyc(DLY + PLS + 20);
        check(fall_cnt == f0 + 1, "R11 clear keeps pulse", fall_cnt - f0, 1);
        check(fall_cyc - c0 == DLY, "R11 delay intact", fall_cyc - c0, DLY);
        check(rise_cyc - fall_cyc == PLS, "R11 width intact", rise_cyc - fall_cyc, PLS);
    endtask

    task automatic t_busy_ignore();
        int c0; int cx; int f0;
        f0 = fall_cnt;
        bus_write(PA, 8'h01, c0);
        wait_cyc(100);
        bus_write(PA, 8'h00, cx);
        bus_write(PA, 8'h01, cx);
        wait_cyc(DLY + 200);
        bus_write(PA, 8'h00, cx);
        bus_write(PA, 8'h01, cx);
        wait_cyc(2 * (DLY + PLS) + 40);
        check(fall_cnt == f0 + 1, "R12 single pulse", fall_cnt - f0, 1);
        check(fall_cyc - c0 == DLY, "R12 first pulse timing", fall_cyc - c0, DLY);
        bus_write(PA, 8'h00, cx);
    endtask

    task automatic t_reset_abort();
        logic [7:0] d; logic oe; int c0;
        bus_write(PA, 8'h03, c0);
        wait_cyc(DLY + 100);
        check(alt_rst_n == 1'b0, "R10 pulse in progress", int'(alt_rst_n), 0);
        rst_n = 1'b0; #1;
        check(alt_rst_n == 1'b1, "R10 reset forces high", int'(alt_rst_n), 1);
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(PLS + 20);
        check(alt_rst_n == 1'b1, "R10 sequence abandoned", int'(alt_rst_n), 1);
        bus_read(PA, d, oe);
        check(d == 8'h00, "R2 reset clears bits", int'(d), 0);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset_state();
        t_a20_truth();
        t_readback_reserved();
        t_addr_decode();
        t_disabled();
        t_pulse_timing();
        t_no_retrigger();
        t_clear_midway();
        t_busy_ignore();
        t_reset_abort();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule